// File: doc/BRIEF.md
# Masked Interrupt Class Arbiter

This block decides which interrupt class a processor core services next. It keeps a small pending state: a last-in first-out queue of machine-check requests, a last-in first-out queue of external requests, and single-bit flags for the clock-comparator (TOD) event, the CPU-timer event and the I/O class. When the core strobes `take_i`, the arbiter looks at that state and at the class-enable bits from the current status word. One cycle later it emits a single-cycle grant. The grant carries the chosen class, a 16-bit interruption code and a 32-bit parameter, and the arbiter updates its own pending state at the same time.

A synchronous exception that the core has already latched, either a program check or a supervisor call, always wins over the asynchronous classes. Among the asynchronous classes the order is fixed: machine check first, then external, then I/O. The external class turns TOD and CPU-timer events into grants with fixed codes when no queued external request is waiting. `cpu_irq_o` tells the core whether anything at all is still pending.

Top module: `irq_class_arbiter`

## Requirements
- R1: When `take_i` is sampled high while `exc_pend_i` is high, the next cycle grants class PGM (`exc_kind_i`=0) or SVC (`exc_kind_i`=1) with code `exc_code_i`. No pending state is consumed.
- R2: Without a latched exception, the arbiter considers machine check, then external, then I/O. A class is considered only when its enable bit is set: `class_en_i[2]` for machine check, `class_en_i[1]` for external, `class_en_i[0]` for I/O.
- R3: Inside the external class, a queued request wins over a pending TOD event, and a pending TOD event wins over a pending CPU-timer event. TOD grants carry code 0x1004 and CPU-timer grants carry code 0x1005, both with parameter 0.
- R4: Servicing a TOD event clears the TOD flag. Servicing a CPU-timer event clears the CPU-timer flag.
- R5: Queued requests are granted last-in first-out. Each grant pops the top entry and presents that entry's code and parameter.
- R6: A queued class stays pending until its queue is empty. After that, a take falls through to the next enabled class.
- R7: If machine check is enabled and pending while `mck_gate_i` is low, a take produces no grant. The entry is not consumed and lower classes are not serviced.
- R8: If the top machine-check entry has a kind other than 1, a gated take discards that entry, produces no grant, and sets the sticky `mck_err_o`.
- R9: A pulse on `io_set_i` makes the I/O class pending. An I/O grant (code 0, parameter 0) clears it.
- R10: A grant is registered one cycle after the take and lasts one cycle. When nothing is eligible, no grant is made. Class codes: NONE=0, PGM=1, SVC=2, MCHK=3, EXT=4, IO=5.
- R11: `cpu_irq_o` is high exactly when either queue is non-empty or any of the TOD, CPU-timer or I/O flags is set.
- R12: Each queue holds 8 entries. A push onto a full queue is dropped and sets that queue's sticky overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Core asks for an arbitration this cycle |
| exc_pend_i | input | 1 | A synchronous exception is latched |
| exc_kind_i | input | 1 | 0 = program check, 1 = supervisor call |
| exc_code_i | input | 16 | Code of the latched exception |
| class_en_i | input | 3 | Enables: [2] machine check, [1] external, [0] I/O |
| mck_gate_i | input | 1 | Machine-check delivery gate from control state |
| tod_set_i | input | 1 | Sets the TOD event flag |
| cpt_set_i | input | 1 | Sets the CPU-timer event flag |
| io_set_i | input | 1 | Sets the I/O pending flag |
| ext_push_i | input | 1 | Push an external request |
| ext_code_i | input | 16 | Code of the pushed external request |
| ext_parm_i | input | 32 | Parameter of the pushed external request |
| mck_push_i | input | 1 | Push a machine-check request |
| mck_kind_i | input | 4 | Kind of the pushed machine-check request |
| mck_code_i | input | 16 | Code of the pushed machine-check request |
| mck_parm_i | input | 32 | Parameter of the pushed machine-check request |
| grant_o | output | 1 | One-cycle grant strobe |
| grant_cls_o | output | 3 | Granted class |
| grant_code_o | output | 16 | Granted interruption code |
| grant_parm_o | output | 32 | Granted parameter |
| cpu_irq_o | output | 1 | Something is pending |
| ext_ovf_o | output | 1 | Sticky external-queue overflow |
| mck_ovf_o | output | 1 | Sticky machine-check-queue overflow |
| mck_err_o | output | 1 | Sticky bad machine-check kind |

## Verification
The selection logic is driven with several pending-state mixes:
- A latched exception on top of a queued request separates exception precedence from ordinary arbitration.
- Three stacked external requests followed by an I/O event show last-in first-out order and that the pending state clears only once the queue is empty.
- A queued request together with TOD and CPU-timer flags pins down the order and the fixed codes inside the external class.
- Walking the enable bits over a machine-check, external and I/O mix shows that masking skips a class rather than stalling.
- Gate-off, bad-kind and nine-push cases tell a held machine check apart from a discarded one, and a dropped push apart from a stored one.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int CODE_W = 16;
    localparam int PARM_W = 32;
    localparam int KIND_W = 4;

    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_PGM  = 3'd1,
        CLS_SVC  = 3'd2,
        CLS_MCHK = 3'd3,
        CLS_EXT  = 3'd4,
        CLS_IO   = 3'd5
    } cls_e;

    typedef enum logic [3:0] {
        PK_NONE,
        PK_EXC,
        PK_MCK_OK,
        PK_MCK_BAD,
        PK_MCK_HOLD,
        PK_EXT_Q,
        PK_TOD,
        PK_CPT,
        PK_IO
    } pick_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PARM_W-1:0] parm;
    } ext_ent_t;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [CODE_W-1:0] code;
        logic [PARM_W-1:0] parm;
    } mck_ent_t;

    typedef struct packed {
        logic tod;
        logic cpt;
        logic io;
    } evt_t;

    localparam logic [CODE_W-1:0] TOD_CODE    = 16'h1004;
    localparam logic [CODE_W-1:0] CPT_CODE    = 16'h1005;
    localparam logic [KIND_W-1:0] MCK_KIND_OK = 4'd1;

endpackage

// File: rtl/irq_lifo.sv
module irq_lifo #(
    parameter int DEPTH = 8,
    parameter int W     = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         nonempty,
    output logic         ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic          full;
    logic [AW-1:0] top_idx;
    logic [AW-1:0] wr_idx;
    logic          do_pop;

    assign full     = (cnt == CW'(DEPTH));
    assign nonempty = (cnt != '0);
    assign do_pop   = pop && nonempty;
    assign top_idx  = AW'(cnt - 1'b1);
    assign wr_idx   = do_pop ? top_idx : AW'(cnt);
    assign top      = mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (do_pop) begin
            if (!push) cnt <= cnt - 1'b1;
        end else if (push) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + 1'b1;
        end
    end

    // Entry storage: a simultaneous push and pop overwrites the top slot.
    always_ff @(posedge clk) begin
        if (push && (do_pop || !full)) mem[wr_idx] <= din;
    end

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);
    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
(
    input  logic                exc_pend,
    input  logic                exc_kind,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic [2:0]          class_en,
    input  logic                mck_gate,
    input  logic                mck_ne,
    input  mck_ent_t            mck_top,
    input  logic                ext_ne,
    input  ext_ent_t            ext_top,
    input  evt_t                evt,
    output pick_e               pick,
    output cls_e                cls,
    output logic [CODE_W-1:0]   code,
    output logic [PARM_W-1:0]   parm
);
    always_comb begin
        pick = PK_NONE;
        cls  = CLS_NONE;
        code = '0;
        parm = '0;
        if (exc_pend) begin
            pick = PK_EXC;
            cls  = exc_kind ? CLS_SVC : CLS_PGM;
            code = exc_code;
        end else if (class_en[2] && mck_ne) begin
            if (!mck_gate) begin
                pick = PK_MCK_HOLD;
            end else if (mck_top.kind != MCK_KIND_OK) begin
                pick = PK_MCK_BAD;
            end else begin
                pick = PK_MCK_OK;
                cls  = CLS_MCHK;
                code = mck_top.code;
                parm = mck_top.parm;
            end
        end else if (class_en[1] && (ext_ne || evt.tod || evt.cpt)) begin
            cls = CLS_EXT;
            if (ext_ne) begin
                pick = PK_EXT_Q;
                code = ext_top.code;
                parm = ext_top.parm;
            end else if (evt.tod) begin
                pick = PK_TOD;
                code = TOD_CODE;
            end else begin
                pick = PK_CPT;
                code = CPT_CODE;
            end
        end else if (class_en[0] && evt.io) begin
            pick = PK_IO;
            cls  = CLS_IO;
        end
    end
endmodule

// File: rtl/irq_class_arbiter.sv
module irq_class_arbiter
    import irq_arb_pkg::*;
#(
    parameter int EXT_DEPTH = 8,
    parameter int MCK_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        take_i,
    input  logic        exc_pend_i,
    input  logic        exc_kind_i,
    input  logic [15:0] exc_code_i,
    input  logic [2:0]  class_en_i,
    input  logic        mck_gate_i,
    input  logic        tod_set_i,
    input  logic        cpt_set_i,
    input  logic        io_set_i,
    input  logic        ext_push_i,
    input  logic [15:0] ext_code_i,
    input  logic [31:0] ext_parm_i,
    input  logic        mck_push_i,
    input  logic [3:0]  mck_kind_i,
    input  logic [15:0] mck_code_i,
    input  logic [31:0] mck_parm_i,
    output logic        grant_o,
    output logic [2:0]  grant_cls_o,
    output logic [15:0] grant_code_o,
    output logic [31:0] grant_parm_o,
    output logic        cpu_irq_o,
    output logic        ext_ovf_o,
    output logic        mck_ovf_o,
    output logic        mck_err_o
);
    localparam int EXT_W = $bits(ext_ent_t);
    localparam int MCK_W = $bits(mck_ent_t);

    evt_t        evt_q;
    ext_ent_t    ext_in, ext_top;
    mck_ent_t    mck_in, mck_top;
    logic        ext_ne, mck_ne, ext_pop, mck_pop;
    pick_e       pick;
    cls_e        cls;
    logic [CODE_W-1:0] code;
    logic [PARM_W-1:0] parm;

    assign ext_in  = '{code: ext_code_i, parm: ext_parm_i};
    assign mck_in  = '{kind: mck_kind_i, code: mck_code_i, parm: mck_parm_i};
    assign ext_pop = take_i && (pick == PK_EXT_Q);
    assign mck_pop = take_i && ((pick == PK_MCK_OK) || (pick == PK_MCK_BAD));

    irq_lifo #(.DEPTH(EXT_DEPTH), .W(EXT_W)) u_ext_q (
        .clk(clk), .rst(rst), .push(ext_push_i), .pop(ext_pop),
        .din(ext_in), .top(ext_top), .nonempty(ext_ne), .ovf(ext_ovf_o)
    );

    irq_lifo #(.DEPTH(MCK_DEPTH), .W(MCK_W)) u_mck_q (
        .clk(clk), .rst(rst), .push(mck_push_i), .pop(mck_pop),
        .din(mck_in), .top(mck_top), .nonempty(mck_ne), .ovf(mck_ovf_o)
    );

    irq_pick u_pick (
        .exc_pend(exc_pend_i), .exc_kind(exc_kind_i), .exc_code(exc_code_i),
        .class_en(class_en_i), .mck_gate(mck_gate_i),
        .mck_ne(mck_ne), .mck_top(mck_top), .ext_ne(ext_ne), .ext_top(ext_top),
        .evt(evt_q), .pick(pick), .cls(cls), .code(code), .parm(parm)
    );

    // Event flags: a new set in the same cycle as a service wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q.tod <= (evt_q.tod && !(take_i && pick == PK_TOD)) || tod_set_i;
            evt_q.cpt <= (evt_q.cpt && !(take_i && pick == PK_CPT)) || cpt_set_i;
            evt_q.io  <= (evt_q.io  && !(take_i && pick == PK_IO))  || io_set_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o      <= 1'b0;
            grant_cls_o  <= CLS_NONE;
            grant_code_o <= '0;
            grant_parm_o <= '0;
            mck_err_o    <= 1'b0;
        end else begin
            grant_o      <= take_i && (cls != CLS_NONE);
            grant_cls_o  <= take_i ? cls : CLS_NONE;
            grant_code_o <= take_i ? code : '0;
            grant_parm_o <= take_i ? parm : '0;
            if (take_i && pick == PK_MCK_BAD) mck_err_o <= 1'b1;
        end
    end

    assign cpu_irq_o = ext_ne || mck_ne || evt_q.tod || evt_q.cpt || evt_q.io;

    p_exc_first_r1: assert property (@(posedge clk) disable iff (rst)
        (take_i && exc_pend_i) |=>
            (grant_o && (grant_cls_o == CLS_PGM || grant_cls_o == CLS_SVC)));
    p_mck_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (take_i && !exc_pend_i && class_en_i[2] && mck_ne && !mck_gate_i) |=>
            (!grant_o && mck_ne));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        mck_err_o |=> mck_err_o);
    p_grant_after_take_r10: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> $past(take_i));
endmodule

// File: tb/tb_irq_class_arbiter.sv
module tb_irq_class_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        take_i = 0, exc_pend_i = 0, exc_kind_i = 0;
    logic [15:0] exc_code_i = 0;
    logic [2:0]  class_en_i = 3'b111;
    logic        mck_gate_i = 1;
    logic        tod_set_i = 0, cpt_set_i = 0, io_set_i = 0;
    logic        ext_push_i = 0, mck_push_i = 0;
    logic [15:0] ext_code_i = 0, mck_code_i = 0;
    logic [31:0] ext_parm_i = 0, mck_parm_i = 0;
    logic [3:0]  mck_kind_i = 0;
    logic        grant_o, cpu_irq_o, ext_ovf_o, mck_ovf_o, mck_err_o;
    logic [2:0]  grant_cls_o;
    logic [15:0] grant_code_o;
    logic [31:0] grant_parm_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_class_arbiter dut (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic take();
        @(negedge clk) take_i = 1;
        @(negedge clk) take_i = 0;
    endtask

    task automatic expect_grant(string req, logic [2:0] c, logic [15:0] code, logic [31:0] parm);
        take();
        check(req, {grant_o, grant_cls_o, grant_code_o, grant_parm_o}, {1'b1, c, code, parm});
    endtask

    task automatic expect_none(string req);
        take();
        check(req, grant_o, 1'b0);
    endtask

    task automatic push_ext(logic [15:0] c, logic [31:0] p);
        @(negedge clk) begin ext_push_i = 1; ext_code_i = c; ext_parm_i = p; end
        @(negedge clk) ext_push_i = 0;
    endtask

    task automatic push_mck(logic [3:0] k, logic [15:0] c, logic [31:0] p);
        @(negedge clk) begin mck_push_i = 1; mck_kind_i = k; mck_code_i = c; mck_parm_i = p; end
        @(negedge clk) mck_push_i = 0;
    endtask

    task automatic pulse(logic t, logic c, logic i);
        @(negedge clk) begin tod_set_i = t; cpt_set_i = c; io_set_i = i; end
        @(negedge clk) begin tod_set_i = 0; cpt_set_i = 0; io_set_i = 0; end
    endtask

    task automatic t_reset();
        check("R10 reset grant", grant_o, 0);
        check("R11 reset irq", cpu_irq_o, 0);
        check("R12 reset ovf", {ext_ovf_o, mck_ovf_o}, 0);
        check("R8 reset err", mck_err_o, 0);
    endtask

    task automatic t_exc();
        push_ext(16'h0040, 32'h11);
        exc_pend_i = 1; exc_kind_i = 1; exc_code_i = 16'h00AB;
        expect_grant("R1 svc wins", 3'd2, 16'h00AB, 0);
        exc_kind_i = 0; exc_code_i = 16'h0007;
        expect_grant("R1 pgm wins", 3'd1, 16'h0007, 0);
        exc_pend_i = 0;
        expect_grant("R1 ext not consumed", 3'd4, 16'h0040, 32'h11);
        @(negedge clk);
        check("R10 grant one cycle", grant_o, 0);
    endtask

    task automatic t_lifo();
        push_ext(16'h0101, 32'hA1);
        push_ext(16'h0202, 32'hA2);
        push_ext(16'h0303, 32'hA3);
        pulse(0, 0, 1);
        expect_grant("R5 lifo top", 3'd4, 16'h0303, 32'hA3);
        expect_grant("R5 lifo second", 3'd4, 16'h0202, 32'hA2);
        check("R11 irq with entries", cpu_irq_o, 1);
        expect_grant("R6 last entry", 3'd4, 16'h0101, 32'hA1);
        expect_grant("R6 falls to io", 3'd5, 16'h0000, 0);
        check("R9 io cleared irq", cpu_irq_o, 0);
        expect_none("R9 io consumed");
    endtask

    task automatic t_ext_order();
        pulse(1, 1, 0);
        push_ext(16'h2222, 32'h5);
        expect_grant("R3 queued first", 3'd4, 16'h2222, 32'h5);
        expect_grant("R3 tod code", 3'd4, 16'h1004, 0);
        expect_grant("R3 cpt code", 3'd4, 16'h1005, 0);
        check("R4 flags cleared", cpu_irq_o, 0);
        expect_none("R4 nothing left");
    endtask

    task automatic t_enables();
        push_mck(4'd1, 16'h0F1D, 32'h4033);
        push_ext(16'h3333, 32'h6);
        pulse(0, 0, 1);
        class_en_i = 3'b011;
        expect_grant("R2 mchk masked ext", 3'd4, 16'h3333, 32'h6);
        class_en_i = 3'b001;
        expect_grant("R2 io only", 3'd5, 16'h0000, 0);
        class_en_i = 3'b010;
        expect_none("R2 ext empty none");
        class_en_i = 3'b100;
        expect_grant("R2 mchk", 3'd3, 16'h0F1D, 32'h4033);
        class_en_i = 3'b111;
        check("R11 all clear", cpu_irq_o, 0);
    endtask

    task automatic t_gate();
        push_mck(4'd1, 16'h0A0A, 32'h77);
        pulse(0, 0, 1);
        mck_gate_i = 0;
        expect_none("R7 gated no grant");
        check("R7 still pending", cpu_irq_o, 1);
        mck_gate_i = 1;
        expect_grant("R7 mchk kept", 3'd3, 16'h0A0A, 32'h77);
        expect_grant("R2 io after mchk", 3'd5, 16'h0000, 0);
    endtask

    task automatic t_bad();
        push_mck(4'd1, 16'h0006, 32'h66);
        push_mck(4'd2, 16'h0005, 32'h55);
        expect_none("R8 bad kind no grant");
        check("R8 err sticky", mck_err_o, 1);
        expect_grant("R8 next entry", 3'd3, 16'h0006, 32'h66);
        check("R8 err stays", mck_err_o, 1);
    endtask

    task automatic t_ovf();
        for (int i = 1; i <= 9; i++) push_ext(16'(i), 32'(i));
        check("R12 ovf set", ext_ovf_o, 1);
        expect_grant("R12 ninth dropped", 3'd4, 16'd8, 32'd8);
        for (int i = 7; i >= 1; i--) take();
        check("R12 eight stored", cpu_irq_o, 0);
        check("R12 mck ovf clear", mck_ovf_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_exc();
        t_lifo();
        t_ext_order();
        t_enables();
        t_gate();
        t_bad();
        t_ovf();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule